// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of every beat of a short burst from a single start address. A burst runs for up to four accesses. Only the two lowest address bits move through the burst. The bits above them stay fixed at the values loaded with the start address.

The two low bits follow one of two orders. Linear order counts up from the start offset and wraps modulo four. Interleaved order XORs the start offset with the beat number. The order is taken from a mode input when the burst is loaded. The read/write type is also captured at load and stays the same for the whole burst.

A qualified clock edge is one where the active-low clock enable is low. At such an edge, a low load/advance input loads a new burst. A high load/advance input advances the burst, whatever the write flag is. While the clock enable is high, all state holds.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after it is released, `addr` reads 0 and `is_write` reads 0 until the first qualified edge.
- R2: A qualified edge with `load_n` low makes `addr` equal `start_addr` and `is_write` equal `wr_start` after that edge.
- R3: With mode 0 latched at load (linear order), after n advances `addr[1:0]` equals (s + n) mod 4, where s is the start offset `start_addr[1:0]`.
- R4: With mode 1 latched at load (interleaved order), after n advances `addr[1:0]` equals s XOR (n mod 4).
- R5: Advancing never changes `addr[ADDR_W-1:2]`.
- R6: Advancing never changes `is_write`, whatever `wr_start` is at that edge.
- R7: While `en_n` is high, `addr` and `is_write` hold, whatever `load_n`, `start_addr`, `wr_start` and `mode` are.
- R8: After four advances in either mode, `addr` is back at the start address, and further advances repeat the same sequence.
- R9: The order is the value of `mode` at load. Changing `mode` during a burst has no effect until the next load.
- R10: A load at an edge where a burst is still in progress replaces the burst at once. The next address is the new start address, with a beat count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low clock enable; high freezes all state |
| load_n | input | 1 | Low loads a new burst, high advances the current one |
| start_addr | input | ADDR_W | Start address of the burst, sampled at load |
| wr_start | input | 1 | Access type at load: 1 write, 0 read |
| mode | input | 1 | Order at load: 0 linear, 1 interleaved |
| addr | output | ADDR_W | Address of the current beat |
| is_write | output | 1 | Access type latched for the current burst |

## Verification
Two functions can fall in the same cycle: a load can arrive in a cycle where a burst would otherwise advance, and a load or advance request can arrive while the clock enable is high. The bench provokes the first case by reloading after two beats of a running burst. It expects the new start address on the next cycle, with no trace of the old beat count. It provokes the second case by raising `en_n` while `load_n` is low and a different start address, write flag and mode are driven. It expects the address and type to stay frozen, and then expects the burst to continue from where it stopped.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic [OFS_W-1:0] base;
        logic [OFS_W-1:0] beat;
        logic             wr;
        order_e           ord;
    } ctl_t;

endpackage

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_seq_pkg::*;
#(
    parameter int W = OFS_W
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] beat,
    input  order_e       ord,
    output logic [W-1:0] ofs
);

    logic [W-1:0] lin_ofs;
    logic [W-1:0] xor_ofs;

    always_comb begin
        lin_ofs = W'(base + beat);
        xor_ofs = base ^ beat;
        ofs     = (ord == ORD_XOR) ? xor_ofs : lin_ofs;
    end

endmodule

// File: rtl/burst_ctl_next.sv
module burst_ctl_next
    import burst_seq_pkg::*;
(
    input  ctl_t             cur,
    input  logic             en_n,
    input  logic             load_n,
    input  logic [OFS_W-1:0] start_ofs,
    input  logic             wr_start,
    input  logic             mode,
    output ctl_t             nxt
);

    always_comb begin
        nxt = cur;
        if (!en_n) begin
            if (!load_n) begin
                nxt.base = start_ofs;
                nxt.beat = '0;
                nxt.wr   = wr_start;
                nxt.ord  = mode ? ORD_XOR : ORD_LINEAR;
            end else begin
                nxt.beat = OFS_W'(cur.beat + 1'b1);
            end
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_start,
    input  logic              mode,
    output logic [ADDR_W-1:0] addr,
    output logic              is_write
);

    localparam int UP_W = ADDR_W - OFS_W;

    ctl_t            ctl_d, ctl_q;
    logic [UP_W-1:0] up_d, up_q;
    logic [OFS_W-1:0] ofs;

    burst_ctl_next u_next (
        .cur       (ctl_q),
        .en_n      (en_n),
        .load_n    (load_n),
        .start_ofs (start_addr[OFS_W-1:0]),
        .wr_start  (wr_start),
        .mode      (mode),
        .nxt       (ctl_d)
    );

    always_comb begin
        up_d = up_q;
        if (!en_n && !load_n) begin
            up_d = start_addr[ADDR_W-1:OFS_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            up_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            up_q  <= up_d;
        end
    end

    burst_order_gen #(.W(OFS_W)) u_order (
        .base (ctl_q.base),
        .beat (ctl_q.beat),
        .ord  (ctl_q.ord),
        .ofs  (ofs)
    );

    assign addr     = {up_q, ofs};
    assign is_write = ctl_q.wr;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n,
    input logic              load_n,
    input logic [ADDR_W-1:0] start_addr,
    input logic              wr_start,
    input logic              mode,
    input logic [ADDR_W-1:0] addr,
    input logic              is_write
);

    // Independent model of the burst position, kept only for checking.
    logic [1:0] m_start, m_n;
    logic       m_xor;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_start <= '0;
            m_n     <= '0;
            m_xor   <= 1'b0;
        end else if (!en_n) begin
            if (!load_n) begin
                m_start <= start_addr[1:0];
                m_n     <= '0;
                m_xor   <= mode;
            end else begin
                m_n <= m_n + 2'd1;
            end
        end
    end

    always_comb begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (addr == '0 && is_write == 1'b0);
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !load_n) |=> (addr == $past(start_addr) && is_write == $past(wr_start)));

    assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !m_xor |-> (addr[1:0] == 2'(m_start + m_n)));

    assert_interleave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_xor |-> (addr[1:0] == (m_start ^ m_n)));

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && load_n) |=> (addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])));

    assert_type_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && load_n) |=> $stable(is_write));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> ($stable(addr) && $stable(is_write)));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_n       (en_n),
    .load_n     (load_n),
    .start_addr (start_addr),
    .wr_start   (wr_start),
    .mode       (mode),
    .addr       (addr),
    .is_write   (is_write)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_n = 1'b1;
    logic              load_n = 1'b1;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              wr_start = 1'b0;
    logic              mode = 1'b0;
    logic [ADDR_W-1:0] addr;
    logic              is_write;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_n       (en_n),
        .load_n     (load_n),
        .start_addr (start_addr),
        .wr_start   (wr_start),
        .mode       (mode),
        .addr       (addr),
        .is_write   (is_write)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [1:0] beat_ofs(input logic [1:0] s, input int n,
                                            input logic m);
        logic [1:0] nn;
        nn = 2'(n % 4);
        return m ? (s ^ nn) : 2'((s + nn) % 4);
    endfunction

    task automatic do_load(input logic [ADDR_W-1:0] a, input logic w, input logic m);
        en_n = 1'b0; load_n = 1'b0; start_addr = a; wr_start = w; mode = m;
        tick();
        check("R2 addr", addr, a);
        check("R2 type", {{(ADDR_W-1){1'b0}}, is_write}, {{(ADDR_W-1){1'b0}}, w});
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a0;
        #5;
        check("R1 addr in reset", addr, '0);
        check("R1 type in reset", {7'd0, is_write}, 8'd0);
        #30;
        rst_n = 1'b1;
        tick();
        check("R1 addr after release", addr, '0);
        check("R1 type after release", {7'd0, is_write}, 8'd0);

        // Sweep both orders and all start offsets, running past the wrap.
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                a0 = {6'(6'h2D + s * 7 + m), 2'(s)};
                do_load(a0, 1'(s & 1), 1'(m));
                for (int n = 1; n <= 9; n++) begin
                    load_n = 1'b1;
                    wr_start = ~wr_start;
                    mode = ~mode;
                    start_addr = ~start_addr;
                    tick();
                    if (m == 0)
                        check("R3 R9 linear ofs", {6'd0, addr[1:0]},
                              {6'd0, beat_ofs(2'(s), n, 1'b0)});
                    else
                        check("R4 R9 interleaved ofs", {6'd0, addr[1:0]},
                              {6'd0, beat_ofs(2'(s), n, 1'b1)});
                    check("R5 upper", {2'd0, addr[7:2]}, {2'd0, a0[7:2]});
                    check("R6 type", {7'd0, is_write}, {7'd0, 1'(s & 1)});
                    if (n == 4 || n == 8)
                        check("R8 wrap", addr, a0);
                end
            end
        end

        // Freeze while load requested with different data.
        do_load(8'h91, 1'b1, 1'b0);
        load_n = 1'b1;
        tick();
        check("R3 before freeze", addr, 8'h92);
        en_n = 1'b1; load_n = 1'b0; start_addr = 8'h3C; wr_start = 1'b0; mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R7 addr held", addr, 8'h92);
            check("R7 type held", {7'd0, is_write}, 8'd1);
        end
        en_n = 1'b0; load_n = 1'b1;
        tick();
        check("R7 resume", addr, 8'h93);

        // Reload in the middle of a burst.
        do_load(8'h46, 1'b0, 1'b1);
        load_n = 1'b1;
        tick();
        tick();
        check("R4 mid burst", addr, {6'h11, 2'b10 ^ 2'd2});
        do_load(8'hE1, 1'b1, 1'b0);
        check("R10 reload addr", addr, 8'hE1);
        load_n = 1'b1;
        tick();
        check("R10 beat restarted", addr, 8'hE2);
        check("R10 new type", {7'd0, is_write}, 8'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule